// File: doc/BRIEF.md
# Multi-register transfer sequencer

This block runs a block transfer between a set of registers and memory. A 16-bit select mask names any subset of eight data registers and eight address registers. A start pulse captures the mask, the direction, the element size, the addressing mode and a base address. The block then walks the selected registers one at a time and issues one memory request for each. Each request carries the register index, the memory address, the direction and the element size. The register file and the memory sit outside the block.

In the normal (ascending) mode, registers are visited data 0..7, then address 0..7. The address is used as given and then advances by the element size. In the pre-decrement mode, the walk is fully reversed: address 7..0, then data 7..0. The address drops by the element size before each access. For loads, the block presents the returned data to the register file, with word data sign-extended to 32 bits. When the walk ends, the block holds the final address on `end_addr` for the single cycle in which `done` is high.

The controller has three states:
- **IDLE**: waiting for `start`.
- **XFER**: one request is outstanding each cycle.
- **DONE**: the one-cycle completion pulse.

The transitions are:
- **LAUNCH**: IDLE→XFER, on start with a non-empty mask.
- **EMPTY**: IDLE→DONE, on start with an empty mask.
- **ADVANCE**: XFER→XFER, on a handshake with registers still pending.
- **FINISH**: XFER→DONE, on the handshake for the last register.
- **RETIRE**: DONE→IDLE, unconditional.

Top module: `regxfer_seq`

## Requirements
- R1: A start in IDLE with a non-empty mask produces exactly one accepted request (`mem_valid` && `mem_ready`) per mask bit set, and then no further requests.
- R2: Mask bit i selects register index i. Indices 0..7 are data registers 0..7 and indices 8..15 are address registers 0..7 (`mem_idx[3]` = 1 means an address register). In the normal mode, requests come in ascending index order.
- R3: In the pre-decrement mode, requests come in descending index order (15 down to 0).
- R4: In the normal mode, the k-th request (k from 0) uses address base + k·S. S is 2 when `long_sz` = 0 (word) and 4 when `long_sz` = 1 (long).
- R5: In the pre-decrement mode, the k-th request uses address base − (k+1)·S, modulo 2^32.
- R6: While `done` is high, `end_addr` equals base + n·S in the normal mode, or base − n·S in the pre-decrement mode, where n is the number of selected registers.
- R7: While `mem_valid` is high and `mem_ready` is low, the next cycle keeps `mem_valid` high with the same `mem_idx`, `mem_addr` and `mem_write`.
- R8: `done` is high for exactly one cycle, the cycle after the last accepted request. The cycle after that, `busy` is low.
- R9: A start with an empty mask raises `done` in the next cycle with `end_addr` equal to base and never raises `mem_valid`.
- R10: When `to_mem` = 0 (load), `reg_we` is high exactly in the cycles of accepted requests. In those cycles `reg_widx` = `mem_idx`, and `reg_wdata` = `mem_rdata` for long, or `mem_rdata[15:0]` sign-extended to 32 bits for word. When `to_mem` = 1 (store), `reg_we` stays low.
- R11: `mem_write` equals the `to_mem` value captured at start. A start while `busy` is high is ignored: the running walk keeps its order, addresses and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (honoured only in IDLE) |
| sel_mask | input | 16 | Register select mask, bit i = register index i |
| to_mem | input | 1 | 1 = register to memory, 0 = memory to register |
| long_sz | input | 1 | 1 = 32-bit elements, 0 = 16-bit elements |
| predec | input | 1 | 1 = pre-decrement reversed walk |
| base_addr | input | 32 | Starting address |
| mem_valid | output | 1 | Request valid |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_write | output | 1 | Request direction, 1 = write to memory |
| mem_long | output | 1 | Request element size, 1 = long |
| mem_idx | output | 4 | Register index of the request |
| mem_addr | output | 32 | Memory address of the request |
| mem_rdata | input | 32 | Load data, valid with `mem_ready` |
| reg_we | output | 1 | Register file write strobe |
| reg_widx | output | 4 | Register file write index |
| reg_wdata | output | 32 | Register file write data |
| busy | output | 1 | Walk in progress (XFER or DONE) |
| done | output | 1 | One-cycle completion pulse |
| end_addr | output | 32 | Final address, valid while `done` is high |

## Verification
The first request is due in the first cycle after the start edge. Each later request is due in the cycle after the previous accepted one. `done` is due in the cycle after the last acceptance, or in the cycle after start for an empty mask. The bench drives `start` and `mem_ready` at the falling edge, waits one time unit, and then compares `mem_idx`, `mem_addr`, `mem_write`, `reg_we` and `reg_wdata` in that same half-cycle, because the write strobe follows `mem_ready` combinationally. A per-walk count of accepted requests tells the bench the exact sample at which `done` and `end_addr` must appear, and the sample after that at which `done` and `busy` must have dropped. The sweep covers every combination of direction, size and mode with 32 masks, under a repeating pattern of stalls.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;

    localparam int XFER_DW = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;

    // Load data as it must land in a 32-bit register.
    function automatic logic [XFER_DW-1:0] widen_load(
        input logic [XFER_DW-1:0] raw,
        input logic               is_long
    );
        logic [XFER_DW-1:0] res;
        if (is_long)
            res = raw;
        else
            res = {{(XFER_DW-16){raw[15]}}, raw[15:0]};
        return res;
    endfunction

endpackage

// File: rtl/regxfer_pick.sv
module regxfer_pick #(
    parameter int NREG = 16,
    parameter int IW   = $clog2(NREG)
) (
    input  logic [NREG-1:0] mask,
    input  logic            rev,
    output logic            any,
    output logic [IW-1:0]   idx
);

    logic [NREG-1:0] view;
    logic [IW-1:0]   pos;

    // Mirror the mask in reversed mode so a single lowest-bit search serves both orders.
    generate
        for (genvar g = 0; g < NREG; g++) begin : g_view
            assign view[g] = rev ? mask[NREG-1-g] : mask[g];
        end
    endgenerate

    always_comb begin
        pos = '0;
        any = 1'b0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (view[i]) begin
                pos = IW'(i);
                any = 1'b1;
            end
        end
    end

    assign idx = rev ? (IW'(NREG - 1) - pos) : pos;

    // The chosen index must be a selected register (R2, R3).
    always_comb begin
        if (any) begin
            p_pick_hit_r2: assert (mask[idx] == 1'b1)
                else $error("picker chose an unselected register");
        end
    end

endmodule

// File: rtl/regxfer_addr.sv
module regxfer_addr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [AW-1:0] load_val,
    input  logic          step_en,
    input  logic          dec,
    input  logic          long_sz,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] req_addr
);

    logic [AW-1:0] step;
    logic [AW-1:0] lowered;
    logic [AW-1:0] raised;

    assign step     = long_sz ? AW'(4) : AW'(2);
    assign lowered  = cur_addr - step;
    assign raised   = cur_addr + step;
    // Pre-decrement presents the lowered address; normal mode presents the current one.
    assign req_addr = dec ? lowered : cur_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_addr <= '0;
        else if (load_en)
            cur_addr <= load_val;
        else if (step_en)
            cur_addr <= dec ? lowered : raised;
    end

    p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en && !dec) |=> (cur_addr == $past(req_addr) + $past(step)))
        else $error("ascending step wrong");

    p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en && dec) |=> (cur_addr == $past(req_addr)))
        else $error("descending step wrong");

endmodule

// File: rtl/regxfer_seq.sv
module regxfer_seq
    import regxfer_pkg::*;
#(
    parameter int NREG = 16,
    parameter int AW   = 32,
    parameter int IW   = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [NREG-1:0]    sel_mask,
    input  logic               to_mem,
    input  logic               long_sz,
    input  logic               predec,
    input  logic [AW-1:0]      base_addr,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic               mem_write,
    output logic               mem_long,
    output logic [IW-1:0]      mem_idx,
    output logic [AW-1:0]      mem_addr,
    input  logic [XFER_DW-1:0] mem_rdata,
    output logic               reg_we,
    output logic [IW-1:0]      reg_widx,
    output logic [XFER_DW-1:0] reg_wdata,
    output logic               busy,
    output logic               done,
    output logic [AW-1:0]      end_addr
);

    seq_state_t      state, state_nx;
    logic [NREG-1:0] pend;
    logic [NREG-1:0] hit_onehot;
    logic [NREG-1:0] pend_after;
    logic            dir_q, long_q, dec_q;
    logic            launch;
    logic            accept;
    logic            pick_any;
    logic [IW-1:0]   pick_idx;
    logic [AW-1:0]   cur_addr;
    logic [AW-1:0]   req_addr;

    assign launch = (state == ST_IDLE) && start;
    assign accept = (state == ST_XFER) && mem_ready;

    regxfer_pick #(.NREG(NREG), .IW(IW)) u_pick (
        .mask (pend),
        .rev  (dec_q),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    regxfer_addr #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (launch),
        .load_val (base_addr),
        .step_en  (accept),
        .dec      (dec_q),
        .long_sz  (long_q),
        .cur_addr (cur_addr),
        .req_addr (req_addr)
    );

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_hit
            assign hit_onehot[g] = (pick_idx == IW'(g));
        end
    endgenerate

    assign pend_after = pend & ~hit_onehot;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Captured walk configuration and remaining-register set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend   <= '0;
            dir_q  <= 1'b0;
            long_q <= 1'b0;
            dec_q  <= 1'b0;
        end else if (launch) begin
            pend   <= sel_mask;
            dir_q  <= to_mem;
            long_q <= long_sz;
            dec_q  <= predec;
        end else if (accept) begin
            pend   <= pend_after;
        end
    end

    // Next state: LAUNCH, EMPTY, ADVANCE, FINISH, RETIRE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start)
                    state_nx = (sel_mask == '0) ? ST_DONE : ST_XFER;
            end
            ST_XFER: begin
                if (mem_ready && (pend_after == '0))
                    state_nx = ST_DONE;
            end
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_valid = 1'b0;
        reg_we    = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_XFER: begin
                mem_valid = 1'b1;
                busy      = 1'b1;
                reg_we    = mem_ready && !dir_q;
            end
            ST_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_write = dir_q;
    assign mem_long  = long_q;
    assign mem_idx   = pick_idx;
    assign mem_addr  = req_addr;
    assign reg_widx  = pick_idx;
    assign reg_wdata = widen_load(mem_rdata, long_q);
    assign end_addr  = cur_addr;

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_idx) && $stable(mem_addr) && $stable(mem_write)))
        else $error("request changed while stalled");

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy))
        else $error("done longer than one cycle");

    p_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (sel_mask == '0)) |=> (done && !mem_valid))
        else $error("empty mask did not complete at once");

    p_store_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_write |-> !reg_we)
        else $error("register written during store");

    p_we_on_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (mem_valid && mem_ready))
        else $error("register write without handshake");

    p_dir_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && $past(mem_valid)) |-> $stable(mem_write))
        else $error("direction changed mid-walk");

    p_xfer_has_work_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> pick_any)
        else $error("request with no pending register");

endmodule

// File: tb/regxfer_seq_tb.sv
module regxfer_seq_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] sel_mask = '0;
    logic        to_mem = 1'b0;
    logic        long_sz = 1'b0;
    logic        predec = 1'b0;
    logic [31:0] base_addr = '0;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic        mem_write;
    logic        mem_long;
    logic [3:0]  mem_idx;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        reg_we;
    logic [3:0]  reg_widx;
    logic [31:0] reg_wdata;
    logic        busy;
    logic        done;
    logic [31:0] end_addr;

    int vectors = 0;
    int errors  = 0;
    int tick    = 0;

    regxfer_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .sel_mask(sel_mask),
        .to_mem(to_mem), .long_sz(long_sz), .predec(predec), .base_addr(base_addr),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_long(mem_long), .mem_idx(mem_idx), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .reg_we(reg_we), .reg_widx(reg_widx),
        .reg_wdata(reg_wdata), .busy(busy), .done(done), .end_addr(end_addr)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic int popc(input logic [15:0] m);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(m[i]);
        return c;
    endfunction

    function automatic logic [3:0] next_idx(input logic [15:0] m, input bit rev);
        logic [3:0] r = '0;
        if (rev) begin
            for (int i = 0; i < 16; i++) if (m[i]) r = 4'(i);
        end else begin
            for (int i = 15; i >= 0; i--) if (m[i]) r = 4'(i);
        end
        return r;
    endfunction

    task automatic run_case(input logic [15:0] m, input bit dir, input bit lng,
                            input bit dec, input logic [31:0] base, input bit inject);
        logic [15:0] pend = m;
        int          n = popc(m);
        int          k = 0;
        int          guard = 0;
        logic [31:0] step = lng ? 32'd4 : 32'd2;
        logic [31:0] exp_a, exp_w, held_a;
        logic [3:0]  exp_i, held_i;
        bit          stalled = 0;
        bit          inj_on = 0;
        @(negedge clk);
        sel_mask = m; to_mem = dir; long_sz = lng; predec = dec; base_addr = base;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        forever begin
            tick++;
            mem_ready = ((tick * 7 + 3) % 5) != 0;
            mem_rdata = 32'h9E37_79B9 * 32'(tick);
            if (inj_on) begin
                start = 1'b0; sel_mask = m; to_mem = dir; inj_on = 0;
            end
            #1;
            if (k == n) begin
                check(done === 1'b1, (n == 0) ? "R9" : "R8", "done due", 32'(done), 32'd1);
                check(mem_valid === 1'b0, (n == 0) ? "R9" : "R1", "no request at end",
                      32'(mem_valid), 32'd0);
                exp_a = dec ? base - 32'(n) * step : base + 32'(n) * step;
                check(end_addr === exp_a, (n == 0) ? "R9" : "R6", "end_addr", end_addr, exp_a);
                @(negedge clk); #1;
                check(done === 1'b0 && busy === 1'b0, "R8", "done dropped",
                      {30'd0, done, busy}, 32'd0);
                break;
            end
            check(done === 1'b0, "R8", "done early", 32'(done), 32'd0);
            if (mem_valid !== 1'b1) begin
                check(1'b0, "R1", "request missing", 32'(mem_valid), 32'd1);
                break;
            end
            exp_i = next_idx(pend, dec);
            exp_a = dec ? base - 32'(k + 1) * step : base + 32'(k) * step;
            if (stalled) begin
                check(mem_idx === held_i && mem_addr === held_a, "R7", "held request",
                      mem_addr, held_a);
            end
            if (mem_ready) begin
                check(mem_idx === exp_i, dec ? "R3" : "R2", "index", 32'(mem_idx), 32'(exp_i));
                check(mem_addr === exp_a, dec ? "R5" : "R4", "address", mem_addr, exp_a);
                check(mem_write === dir, "R11", "direction", 32'(mem_write), 32'(dir));
                if (dir) begin
                    check(reg_we === 1'b0, "R10", "store write strobe", 32'(reg_we), 32'd0);
                end else begin
                    exp_w = lng ? mem_rdata : {{16{mem_rdata[15]}}, mem_rdata[15:0]};
                    check(reg_we === 1'b1 && reg_widx === exp_i, "R10", "load strobe/index",
                          {27'd0, reg_we, reg_widx}, {27'd0, 1'b1, exp_i});
                    check(reg_wdata === exp_w, "R10", "load data", reg_wdata, exp_w);
                end
                pend[exp_i] = 1'b0;
                k++;
                stalled = 0;
            end else begin
                check(reg_we === 1'b0, "R10", "strobe while stalled", 32'(reg_we), 32'd0);
                stalled = 1; held_i = mem_idx; held_a = mem_addr;
            end
            if (inject && k == 1) begin
                start = 1'b1; sel_mask = ~m; to_mem = ~dir; inj_on = 1;
            end
            guard++;
            if (guard > 200) begin
                check(1'b0, "R1", "walk hung", 32'(k), 32'(n));
                break;
            end
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog expired: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : stim
        logic [15:0] masks [32];
        masks[0] = 16'h0000; masks[1] = 16'hFFFF; masks[2] = 16'h0001; masks[3] = 16'h8000;
        masks[4] = 16'h00FF; masks[5] = 16'hFF00; masks[6] = 16'hA5A5; masks[7] = 16'h0180;
        for (int j = 8; j < 32; j++) masks[j] = 16'(j * 16'h9E37) ^ 16'(j << 3);
        repeat (3) @(negedge clk);
        #1;
        check(busy === 1'b0 && done === 1'b0 && mem_valid === 1'b0 && reg_we === 1'b0,
              "R8", "reset state", {28'd0, busy, done, mem_valid, reg_we}, 32'd0);
        rst_n = 1'b1;
        for (int md = 0; md < 8; md++) begin
            for (int j = 0; j < 32; j++) begin
                run_case(masks[j], md[0], md[1], md[2],
                         (j == 3) ? 32'd0 : 32'h0000_1000 + 32'(j * 64), (j % 4) == 1);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule